// File: doc/BRIEF.md
# Erase-Block Nonvolatile Array Model

This block is a synthesizable behavioural model of a nonvolatile array. Storage is split into erase blocks, and each block holds a fixed number of pages of one data word each. A client issues one command at a time on a single-cycle valid strobe. The three commands are reading a page, programming a page and erasing a block. Once a command is accepted the model raises `busy` for that command's latency. It then pulses `done` for one cycle, and the completion status stays on the outputs until the next completion.

Programming can only pull bits low. The word written into the page is the AND of the old contents and the supplied data. If the data asks for a 0 to become a 1, a warning flag is raised, but the AND result is still stored. Erasing sets every page of a block back to all ones and takes far longer than the other commands. Each block counts its accepted erases. Once the count reaches the endurance limit, the block refuses further program and erase commands but can still be read. Addresses whose block field is past the last block are refused with a range error. Contents need no refresh, and reset leaves every block erased with zero wear.

Top module: `flash_erase_mem`

## Requirements
- R1: After reset `busy`, `done`, `err_range`, `err_worn` and `up_flag` are 0, every page reads as all ones, and every block has zero wear.
- R2: A read (`cmd_op` = 2'b01) keeps `busy` high for exactly READ_LAT cycles. The next cycle has `done` = 1 and `rd_data` = the stored word of the page addressed as {block, page}, with the page in the low PAGE_AW bits of `cmd_addr`.
- R3: A program (`cmd_op` = 2'b10) keeps `busy` high for exactly PROG_LAT cycles and stores old AND `cmd_wdata` into the addressed page.
- R4: At the completion of an executed program, `up_flag` is 1 exactly when `cmd_wdata` has a 1 where the stored word had a 0. The AND result is stored anyway.
- R5: An erase (`cmd_op` = 2'b11) keeps `busy` high for exactly ERASE_LAT cycles and sets every page of the addressed block to all ones. The page field is ignored.
- R6: Program and erase leave every page outside their target unchanged.
- R7: A command presented while `busy` is high is ignored, and a strobe with `cmd_op` = 2'b00 starts nothing.
- R8: A command whose block field is NUM_BLOCKS or more keeps `busy` high for 1 cycle, completes with `err_range` = 1, and changes no data.
- R9: Every executed erase adds one to its block's wear count. When a block's count equals ENDURANCE, program and erase to it complete after 1 busy cycle with `err_worn` = 1 and no data change, while reads of it still work.
- R10: `done` is high for one cycle per accepted command. `err_range`, `err_worn`, `up_flag` and `rd_data` change only at completions, and `err_range` and `err_worn` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, taken when `busy` is low |
| cmd_op | input | 2 | 00 none, 01 read, 10 program, 11 erase |
| cmd_addr | input | BLK_AW+PAGE_AW | {block, page} address |
| cmd_wdata | input | DATA_W | Program data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Word from the last executed read |
| err_range | output | 1 | Last command addressed a missing block |
| err_worn | output | 1 | Last command was refused by a worn block |
| up_flag | output | 1 | Last program asked for a 0-to-1 change |

## Verification
The assertions assume that `cmd_valid` is a single-cycle strobe given only while `busy` is low, except where the stimulus deliberately tries to break in on a running command. They also assume the latency parameters are at least 1. The stimulus waits for `busy` to fall before each command and places its intrusion attempts inside a running busy window. The random mix of reads, programs and erases covers the two missing block numbers and wears blocks out. A bench model of the page contents and wear counts predicts every result.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_PROG  = 2'b10,
    OP_ERASE = 2'b11
  } flash_op_e;
endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_erase_pkg::*;
#(
  parameter int READ_LAT  = 2,
  parameter int PROG_LAT  = 8,
  parameter int ERASE_LAT = 64
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_valid,
  input  flash_op_e cmd_op,
  input  logic      reject,
  output logic      accept,
  output logic      busy,
  output logic      complete
);
  localparam int MAX_RP  = (READ_LAT > PROG_LAT) ? READ_LAT : PROG_LAT;
  localparam int MAX_LAT = (ERASE_LAT > MAX_RP) ? ERASE_LAT : MAX_RP;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  typedef enum logic {S_IDLE, S_BUSY} fsm_state_e;

  fsm_state_e       state_q, state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, lat_sel;
  logic             cnt_en;

  always_comb begin
    if (reject) lat_sel = CNT_W'(1);
    else begin
      unique case (cmd_op)
        OP_PROG:  lat_sel = CNT_W'(PROG_LAT);
        OP_ERASE: lat_sel = CNT_W'(ERASE_LAT);
        default:  lat_sel = CNT_W'(READ_LAT);
      endcase
    end
  end

  assign accept = (state_q == S_IDLE) && cmd_valid && (cmd_op != OP_NONE);

  always_comb begin
    state_n  = state_q;
    cnt_n    = cnt_q;
    cnt_en   = 1'b0;
    complete = 1'b0;
    if (state_q == S_IDLE) begin
      if (accept) begin
        state_n = S_BUSY;
        cnt_n   = lat_sel - CNT_W'(1);
        cnt_en  = 1'b1;
      end
    end else begin
      if (cnt_q == '0) begin
        state_n  = S_IDLE;
        complete = 1'b1;
      end else begin
        cnt_n  = cnt_q - CNT_W'(1);
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      if (cnt_en) cnt_q <= cnt_n;
    end
  end

  assign busy = (state_q == S_BUSY);
endmodule

// File: rtl/flash_page_array.sv
module flash_page_array
  import flash_erase_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int BLK_AW     = 3,
  parameter int PAGE_AW    = 2,
  parameter int DATA_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  flash_op_e          op,
  input  logic [BLK_AW-1:0]  blk,
  input  logic [PAGE_AW-1:0] page,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  cur_word
);
  localparam int PAGES     = 1 << PAGE_AW;
  localparam int NUM_WORDS = NUM_BLOCKS * PAGES;
  localparam int IDX_W     = BLK_AW + PAGE_AW;

  logic [DATA_W-1:0] mem_q [NUM_WORDS];
  logic [IDX_W-1:0]  sel_idx;

  assign sel_idx = {blk, page};

  always_comb begin
    cur_word = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (sel_idx == IDX_W'(w)) cur_word = mem_q[w];
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    localparam int W_BLK  = w / PAGES;
    localparam int W_PAGE = w % PAGES;
    logic              hit_blk, prog_hit, erase_hit, word_en;
    logic [DATA_W-1:0] word_n;

    assign hit_blk   = (blk == BLK_AW'(W_BLK));
    assign prog_hit  = wr_en && (op == OP_PROG) && hit_blk && (page == PAGE_AW'(W_PAGE));
    assign erase_hit = wr_en && (op == OP_ERASE) && hit_blk;
    assign word_en   = prog_hit || erase_hit;

    always_comb begin
      if (erase_hit) word_n = '1;
      else           word_n = mem_q[w] & wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem_q[w] <= '1;
      else if (word_en) mem_q[w] <= word_n;
    end
  end
endmodule

// File: rtl/flash_wear_track.sv
module flash_wear_track #(
  parameter int NUM_BLOCKS = 6,
  parameter int BLK_AW     = 3,
  parameter int ENDURANCE  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  erase_en,
  input  logic [BLK_AW-1:0]     blk,
  output logic [NUM_BLOCKS-1:0] worn
);
  localparam int WEAR_W = $clog2(ENDURANCE + 1);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic [WEAR_W-1:0] wear_q;
    logic              inc_en;

    assign inc_en  = erase_en && (blk == BLK_AW'(b)) && !worn[b];
    assign worn[b] = (wear_q == WEAR_W'(ENDURANCE));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wear_q <= '0;
      else if (inc_en) wear_q <= wear_q + WEAR_W'(1);
    end
  end
endmodule

// File: rtl/flash_erase_mem.sv
module flash_erase_mem
  import flash_erase_pkg::*;
#(
  parameter int NUM_BLOCKS = 6,
  parameter int BLK_AW     = 3,
  parameter int PAGE_AW    = 2,
  parameter int DATA_W     = 16,
  parameter int READ_LAT   = 2,
  parameter int PROG_LAT   = 8,
  parameter int ERASE_LAT  = 64,
  parameter int ENDURANCE  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [1:0]                cmd_op,
  input  logic [BLK_AW+PAGE_AW-1:0] cmd_addr,
  input  logic [DATA_W-1:0]         cmd_wdata,
  output logic                      busy,
  output logic                      done,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      err_range,
  output logic                      err_worn,
  output logic                      up_flag
);
  localparam int                BLK_SLOTS = 1 << BLK_AW;
  localparam logic [BLK_AW:0]   NB_LIMIT  = (BLK_AW + 1)'(NUM_BLOCKS);

  logic                  rst_n_i;
  flash_op_e             in_op;
  logic [BLK_AW-1:0]     in_blk;
  logic                  in_range_bad, in_worn_bad, in_reject;
  logic                  accept, complete;
  logic [NUM_BLOCKS-1:0] worn;
  logic [BLK_SLOTS-1:0]  worn_pad;

  flash_op_e             cap_op_q;
  logic [BLK_AW-1:0]     cap_blk_q;
  logic [PAGE_AW-1:0]    cap_page_q;
  logic [DATA_W-1:0]     cap_wdata_q;
  logic                  cap_range_q, cap_worn_q;

  logic                  exec_en;
  logic [DATA_W-1:0]     cur_word;
  logic                  up_n, rd_en;

  flash_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign in_op  = flash_op_e'(cmd_op);
  assign in_blk = cmd_addr[BLK_AW+PAGE_AW-1:PAGE_AW];

  always_comb begin
    worn_pad = '0;
    worn_pad[NUM_BLOCKS-1:0] = worn;
  end

  assign in_range_bad = ({1'b0, in_blk} >= NB_LIMIT);
  assign in_worn_bad  = !in_range_bad && ((in_op == OP_PROG) || (in_op == OP_ERASE))
                        && worn_pad[in_blk];
  assign in_reject    = in_range_bad || in_worn_bad;

  flash_cmd_fsm #(
    .READ_LAT  (READ_LAT),
    .PROG_LAT  (PROG_LAT),
    .ERASE_LAT (ERASE_LAT)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .cmd_valid (cmd_valid),
    .cmd_op    (in_op),
    .reject    (in_reject),
    .accept    (accept),
    .busy      (busy),
    .complete  (complete)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cap_op_q    <= OP_NONE;
      cap_blk_q   <= '0;
      cap_page_q  <= '0;
      cap_wdata_q <= '0;
      cap_range_q <= 1'b0;
      cap_worn_q  <= 1'b0;
    end else if (accept) begin
      cap_op_q    <= in_op;
      cap_blk_q   <= in_blk;
      cap_page_q  <= cmd_addr[PAGE_AW-1:0];
      cap_wdata_q <= cmd_wdata;
      cap_range_q <= in_range_bad;
      cap_worn_q  <= in_worn_bad;
    end
  end

  assign exec_en = complete && !cap_range_q && !cap_worn_q;

  flash_page_array #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLK_AW     (BLK_AW),
    .PAGE_AW    (PAGE_AW),
    .DATA_W     (DATA_W)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_en    (exec_en),
    .op       (cap_op_q),
    .blk      (cap_blk_q),
    .page     (cap_page_q),
    .wdata    (cap_wdata_q),
    .cur_word (cur_word)
  );

  flash_wear_track #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLK_AW     (BLK_AW),
    .ENDURANCE  (ENDURANCE)
  ) u_wear (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .erase_en (exec_en && (cap_op_q == OP_ERASE)),
    .blk      (cap_blk_q),
    .worn     (worn)
  );

  assign up_n  = exec_en && (cap_op_q == OP_PROG) && (|(cap_wdata_q & ~cur_word));
  assign rd_en = exec_en && (cap_op_q == OP_READ);

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      done      <= 1'b0;
      err_range <= 1'b0;
      err_worn  <= 1'b0;
      up_flag   <= 1'b0;
      rd_data   <= '0;
    end else begin
      done <= complete;
      if (complete) begin
        err_range <= cap_range_q;
        err_worn  <= cap_worn_q;
        up_flag   <= up_n;
      end
      if (rd_en) rd_data <= cur_word;
    end
  end
endmodule

// File: rtl/flash_erase_mem_chk.sv
module flash_erase_mem_chk #(
  parameter int ERASE_LAT = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       err_range,
  input logic       err_worn,
  input logic       up_flag
);
  localparam int LEN_W = $clog2(ERASE_LAT + 2);

  logic [LEN_W-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_len <= '0;
    else if (busy) busy_len <= busy_len + LEN_W'(1);
    else           busy_len <= '0;
  end

  // R7
  start_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && (cmd_op != 2'b00)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  err_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_range && err_worn));

  // R10
  range_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_range) |-> done);

  // R4
  up_only_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_flag |-> (!err_range && !err_worn));

  // R5
  busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= LEN_W'(ERASE_LAT));
endmodule

bind flash_erase_mem flash_erase_mem_chk #(.ERASE_LAT(ERASE_LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .done      (done),
  .err_range (err_range),
  .err_worn  (err_worn),
  .up_flag   (up_flag)
);

// File: tb/flash_erase_mem_tb.sv
module flash_erase_mem_tb;
  localparam int NB    = 6;
  localparam int BAW   = 3;
  localparam int PAW   = 2;
  localparam int DW    = 16;
  localparam int RL    = 2;
  localparam int PL    = 8;
  localparam int EL    = 64;
  localparam int ENDUR = 8;
  localparam int AW    = BAW + PAW;
  localparam int PGS   = 1 << PAW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] cmd_wdata = '0;
  logic          busy, done, err_range, err_worn, up_flag;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] ref_mem [NB*PGS];
  int            ref_wear [NB];

  always #4 clk = ~clk;

  flash_erase_mem u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .err_range(err_range), .err_worn(err_worn), .up_flag(up_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] op, input bit rbad, input bit wbad);
    if (rbad) return "R8";
    if (wbad) return "R9";
    case (op)
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R5";
    endcase
  endfunction

  task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] addr,
                         input logic [DW-1:0] wd, input bit intrude);
    int blk, pg, idx, n, exp_lat;
    bit rbad, wbad, rej, exp_up;
    string rq;
    while (busy) @(negedge clk);
    blk  = int'(addr[AW-1:PAW]);
    pg   = int'(addr[PAW-1:0]);
    idx  = blk * PGS + pg;
    rbad = (blk >= NB);
    wbad = !rbad && (op != 2'b01) && (ref_wear[blk] >= ENDUR);
    rej  = rbad || wbad;
    exp_lat = rej ? 1 : (op == 2'b01) ? RL : (op == 2'b10) ? PL : EL;
    exp_up  = !rej && (op == 2'b10) && ((wd & ~ref_mem[idx]) != '0);
    rq = req_of(op, rbad, wbad);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (busy && n < 200) begin
      n++;
      if (intrude && n == 2) begin
        // R7: attempt to program block 0 page 0 to zero while busy
        cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = '0; cmd_wdata = '0;
      end else cmd_valid = 1'b0;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(n == exp_lat, rq, "busy cycles", n, exp_lat);
    chk(done == 1'b1, "R10", "done at completion", done, 1);
    chk(err_range == rbad, "R8", "err_range", err_range, rbad);
    chk(err_worn == wbad, "R9", "err_worn", err_worn, wbad);
    if (op == 2'b10) chk(up_flag == exp_up, "R4", "up_flag", up_flag, exp_up);
    if (!rej) begin
      if (op == 2'b01) chk(rd_data == ref_mem[idx], rq, "rd_data", rd_data, ref_mem[idx]);
      else if (op == 2'b10) ref_mem[idx] = ref_mem[idx] & wd;
      else if (op == 2'b11) begin
        for (int p = 0; p < PGS; p++) ref_mem[blk*PGS+p] = '1;
        ref_wear[blk]++;
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R10", "done single cycle", done, 0);
    chk(busy == 1'b0, "R7", "no restart after intrusion", busy, 0);
  endtask

  function automatic logic [AW-1:0] mk(input int blk, input int pg);
    return {BAW'(blk), PAW'(pg)};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int seed_dummy;
    for (int i = 0; i < NB*PGS; i++) ref_mem[i] = '1;
    for (int b = 0; b < NB; b++) ref_wear[b] = 0;
    seed_dummy = $urandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(done == 0, "R1", "done after reset", done, 0);
    chk(!err_range && !err_worn && !up_flag, "R1", "flags after reset",
        {err_range, err_worn, up_flag}, 0);
    for (int p = 0; p < PGS; p++) run_cmd(2'b01, mk(0, p), '0, 0); // R1 erased pages
    // R7 op 00 starts nothing
    cmd_valid = 1'b1; cmd_op = 2'b00; @(negedge clk); cmd_valid = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R7", "op none ignored", busy, 0);
    // R3/R4 programs
    run_cmd(2'b10, mk(1, 2), 16'hF0F0, 0);
    run_cmd(2'b10, mk(1, 2), 16'hFF00, 0);
    run_cmd(2'b10, mk(1, 2), 16'h0F0F, 0); // R4 asks 0->1
    run_cmd(2'b01, mk(1, 2), '0, 0);
    run_cmd(2'b10, mk(1, 3), 16'h1234, 0);
    run_cmd(2'b10, mk(2, 0), 16'hAAAA, 0);
    // R5/R6 erase block 1, block 2 unchanged
    run_cmd(2'b11, mk(1, 0), '0, 0);
    run_cmd(2'b01, mk(1, 2), '0, 0);
    run_cmd(2'b01, mk(1, 3), '0, 0);
    run_cmd(2'b01, mk(2, 0), '0, 0);
    // R7 intrusion during an erase of block 3
    run_cmd(2'b10, mk(0, 0), 16'h5A5A, 0);
    run_cmd(2'b11, mk(3, 1), '0, 1);
    run_cmd(2'b01, mk(0, 0), '0, 0);
    // R8 out of range
    run_cmd(2'b01, mk(6, 0), '0, 0);
    run_cmd(2'b10, mk(7, 3), '0, 0);
    run_cmd(2'b11, mk(7, 0), '0, 0);
    // R9 wear out block 5
    for (int i = 0; i < ENDUR; i++) run_cmd(2'b11, mk(5, 0), '0, 0);
    run_cmd(2'b10, mk(5, 1), 16'h0000, 0);
    run_cmd(2'b01, mk(5, 1), '0, 0);
    run_cmd(2'b11, mk(5, 1), '0, 0);
    run_cmd(2'b11, mk(4, 1), '0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(1, 3));
      if (op == 2'b11 && ($urandom_range(0, 3) != 0)) op = 2'b01;
      run_cmd(op, AW'($urandom), DW'($urandom), ($urandom_range(0, 9) == 0));
    end
    for (int w = 0; w < NB*PGS; w++) run_cmd(2'b01, AW'(w), '0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule